// File: doc/BRIEF.md
# Two-wire LCD command and data receiver

This block is the write-only serial front end of a segment LCD controller. It watches the two-wire bus through synchronised copies of SCL and SDA. It answers only to a write aimed at one of two reserved 7-bit addresses, and it acknowledges each accepted byte by pulling SDA low. After the address, the bytes alternate between control bytes and payload bytes. Two flag bits in each control byte decide where the payload goes: to the command decoder, which updates the drive configuration registers, or to the display RAM write port.

Display data is written to RAM at the moment its eighth bit is sampled, without waiting for the acknowledge. A data pointer advances after every data byte. At the end of the RAM the pointer carries into a device subaddress. Several of these receivers can share one bus, and each one writes only while the current subaddress matches its own hardware subaddress. Command bytes take effect only once their acknowledge clock has ended.

Top module: `lcdlink_rx`

## Requirements
- R1: An address byte is sent MSB first, with bits 7..1 holding the address and bit 0 holding R/W. The receiver acknowledges only when bits 7..1 equal 0b011100 followed by `addr_sel_i` and R/W is 0. After any other address byte, nothing is acknowledged or written until the next START.
- R2: A read request (bit 0 of the address byte is 1) is not acknowledged, even when the address matches. The bytes that follow it are ignored.
- R3: For every byte that is accepted, `sda_oe_o` goes high after the SCL falling edge that ends the eighth bit. It goes low again after the next SCL falling edge, which ends the acknowledge clock. At all other times it is low.
- R4: The first byte after an accepted address is a control byte. Bit 6 of a control byte chooses where payload goes: 0 sends it to the command decoder, 1 sends it to display RAM. Bit 7 of a control byte decides what follows. When bit 7 is 1, exactly one payload byte follows and then another control byte. When bit 7 is 0, every remaining byte is payload.
- R5: A display data byte is written on the SCL rising edge that samples its eighth bit, as a single-cycle `ram_we_o` pulse at the current pointer. The pointer then increments. After address DEPTH-1 the pointer returns to 0 and the current subaddress increments.
- R6: A RAM write occurs only while the current subaddress equals `hw_sub_i`. The pointer and subaddress advance whether or not the write occurs.
- R7: Mode-set command `10xx_ebmm`: bit 3 sets `disp_en_o`, bit 2 sets `bias_o` (1 = half bias), and bits 1:0 set `mux_o` (00 four backplanes, 01 static, 10 two, 11 three). Every command takes effect at the SCL falling edge that ends its acknowledge clock.
- R8: Command `0ppp_pppp` loads the data pointer; a value of DEPTH or more loads 0. Command `1110_0sss` sets the current subaddress.
- R9: Command `1110_1abb` sets `blink_alt_o` to a and `blink_freq_o` to bb. Command `1111_10io` sets `bank_in_o` to i and `bank_out_o` to o. Any other code with bits 7:6 = 11 has no effect.
- R10: After reset: `mux_o` = 00, and `bias_o`, `disp_en_o`, both bank selects, both blink fields, `sda_oe_o` and `ram_we_o` are all 0. The pointer and subaddress are both 0.
- R11: A repeated START always returns the parser to the address phase. After a STOP, no byte is acknowledged or written until a START and a matching address arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) |
| addr_sel_i | input | 1 | Selects the lowest address bit |
| hw_sub_i | input | SUBW | This device's subaddress |
| ram_we_o | output | 1 | Display RAM write strobe |
| ram_addr_o | output | PTRW | Display RAM write address |
| ram_wdata_o | output | 8 | Display RAM write data |
| mux_o | output | 2 | Backplane multiplex code |
| bias_o | output | 1 | Bias select (1 = half) |
| disp_en_o | output | 1 | Display enable |
| bank_in_o | output | 1 | Input bank select |
| bank_out_o | output | 1 | Output bank select |
| blink_alt_o | output | 1 | Alternate-bank blinking |
| blink_freq_o | output | 2 | Blink frequency code |

## Verification
Every result of this block follows an SCL or SDA level change by exactly three system clocks. Two of those clocks are the synchroniser stages and the third is the edge detector feeding the registered outputs. This holds for the acknowledge drive, for the RAM write pulse after the eighth rising edge, and for a command register update after the acknowledge falling edge. The bench therefore updates its behavioural expectation at the moment it moves a bus line. On every clock it compares the outputs with the expectation recorded two comparison points earlier, and it takes its one-off readings of the acknowledge and registers only several clocks after the last line change, once the outputs have settled.

// File: rtl/lcdlink_pkg.sv
`timescale 1ns/1ps
package lcdlink_pkg;

   typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_CTRL, PH_PAYLOAD} phase_e;

   typedef enum logic [2:0] {OP_NONE, OP_PTR, OP_MODE, OP_DEV, OP_BLINK, OP_BANK} op_e;

   // upper six address bits shared by both reserved slave addresses
   localparam logic [5:0] ADDR_BASE = 6'b011100;

   function automatic op_e decode_op(input logic [7:0] b);
      if (!b[7])                       return OP_PTR;
      else if (b[7:6] == 2'b10)        return OP_MODE;
      else if (b[7:3] == 5'b11100)     return OP_DEV;
      else if (b[7:3] == 5'b11101)     return OP_BLINK;
      else if (b[7:2] == 6'b111110)    return OP_BANK;
      else                             return OP_NONE;
   endfunction

endpackage

// File: rtl/lcdlink_sync.sv
`timescale 1ns/1ps
module lcdlink_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lcdlink_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_d, sda_d;

   // idle bus level is high, so reset to 1 to avoid false edges
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_d  <= scl_ff[STAGES-1];
         sda_d  <= sda_ff[STAGES-1];
      end
   end

   assign scl_o      = scl_ff[STAGES-1];
   assign sda_o      = sda_ff[STAGES-1];
   assign scl_rise_o = scl_o & ~scl_d;
   assign scl_fall_o = ~scl_o & scl_d;
   assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
   assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/lcdlink_frame.sv
`timescale 1ns/1ps
module lcdlink_frame
   import lcdlink_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_s,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_ev,
   input  logic       stop_ev,
   input  logic       addr_sel_i,
   output logic       sda_oe_o,
   output logic       data_stb_o,
   output logic       cmd_stb_o,
   output logic [7:0] byte_o
);

   localparam logic [3:0] LAST_BIT = 4'd7;
   localparam logic [3:0] ACK_WAIT = 4'd8;
   localparam logic [3:0] ACK_SLOT = 4'd9;

   phase_e     phase_q;
   logic [3:0] bitcnt_q;
   logic [7:0] shreg_q;
   logic       ack_q, co_q, rs_q, oe_q;
   logic [7:0] byte_full;
   logic       addr_hit;

   assign byte_full = {shreg_q[6:0], sda_s};
   assign addr_hit  = (byte_full[7:1] == {ADDR_BASE, addr_sel_i}) && !byte_full[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         bitcnt_q <= '0;
         shreg_q  <= '0;
         ack_q    <= 1'b0;
         co_q     <= 1'b0;
         rs_q     <= 1'b0;
         oe_q     <= 1'b0;
      end else if (start_ev) begin
         phase_q  <= PH_ADDR;
         bitcnt_q <= '0;
         oe_q     <= 1'b0;
      end else if (stop_ev) begin
         phase_q  <= PH_IDLE;
         bitcnt_q <= '0;
         oe_q     <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
         if (scl_rise && bitcnt_q < ACK_WAIT) begin
            shreg_q  <= byte_full;
            bitcnt_q <= bitcnt_q + 4'd1;
            if (bitcnt_q == LAST_BIT)
               ack_q <= (phase_q != PH_ADDR) || addr_hit;
         end else if (scl_fall && bitcnt_q == ACK_WAIT) begin
            bitcnt_q <= ACK_SLOT;
            oe_q     <= ack_q;
         end else if (scl_fall && bitcnt_q == ACK_SLOT) begin
            bitcnt_q <= '0;
            oe_q     <= 1'b0;
            unique case (phase_q)
               PH_ADDR:    phase_q <= ack_q ? PH_CTRL : PH_IDLE;
               PH_CTRL: begin
                  co_q    <= shreg_q[7];
                  rs_q    <= shreg_q[6];
                  phase_q <= PH_PAYLOAD;
               end
               PH_PAYLOAD: phase_q <= co_q ? PH_CTRL : PH_PAYLOAD;
               default:    phase_q <= PH_IDLE;
            endcase
         end
      end
   end

   assign sda_oe_o   = oe_q;
   assign data_stb_o = scl_rise && (bitcnt_q == LAST_BIT) && (phase_q == PH_PAYLOAD) && rs_q;
   assign cmd_stb_o  = scl_fall && (bitcnt_q == ACK_SLOT) && (phase_q == PH_PAYLOAD) && !rs_q;
   assign byte_o     = (bitcnt_q == LAST_BIT) ? byte_full : shreg_q;

endmodule

// File: rtl/lcdlink_regs.sv
`timescale 1ns/1ps
module lcdlink_regs
   import lcdlink_pkg::*;
#(
   parameter int DEPTH = 80,
   parameter int SUBW  = 3,
   parameter int PTRW  = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            data_stb_i,
   input  logic            cmd_stb_i,
   input  logic [7:0]      byte_i,
   input  logic [SUBW-1:0] hw_sub_i,
   output logic            ram_we_o,
   output logic [PTRW-1:0] ram_addr_o,
   output logic [7:0]      ram_wdata_o,
   output logic [1:0]      mux_o,
   output logic            bias_o,
   output logic            disp_en_o,
   output logic            bank_in_o,
   output logic            bank_out_o,
   output logic            blink_alt_o,
   output logic [1:0]      blink_freq_o
);

   localparam logic [PTRW-1:0] PTR_LAST = PTRW'(DEPTH - 1);

   logic [PTRW-1:0] ptr_q;
   logic [SUBW-1:0] sub_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q        <= '0;
         sub_q        <= '0;
         ram_we_o     <= 1'b0;
         ram_addr_o   <= '0;
         ram_wdata_o  <= '0;
         mux_o        <= 2'b00;
         bias_o       <= 1'b0;
         disp_en_o    <= 1'b0;
         bank_in_o    <= 1'b0;
         bank_out_o   <= 1'b0;
         blink_alt_o  <= 1'b0;
         blink_freq_o <= 2'b00;
      end else begin
         ram_we_o <= 1'b0;
         if (data_stb_i) begin
            if (sub_q == hw_sub_i) begin
               ram_we_o    <= 1'b1;
               ram_addr_o  <= ptr_q;
               ram_wdata_o <= byte_i;
            end
            if (ptr_q == PTR_LAST) begin
               ptr_q <= '0;
               sub_q <= sub_q + 1'b1;
            end else begin
               ptr_q <= ptr_q + 1'b1;
            end
         end
         if (cmd_stb_i) begin
            unique case (decode_op(byte_i))
               OP_PTR:   ptr_q <= (int'(byte_i[6:0]) < DEPTH) ? byte_i[PTRW-1:0] : '0;
               OP_MODE: begin
                  disp_en_o <= byte_i[3];
                  bias_o    <= byte_i[2];
                  mux_o     <= byte_i[1:0];
               end
               OP_DEV:   sub_q <= byte_i[SUBW-1:0];
               OP_BLINK: begin
                  blink_alt_o  <= byte_i[2];
                  blink_freq_o <= byte_i[1:0];
               end
               OP_BANK: begin
                  bank_in_o  <= byte_i[1];
                  bank_out_o <= byte_i[0];
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/lcdlink_rx.sv
`timescale 1ns/1ps
module lcdlink_rx #(
   parameter int DEPTH       = 80,
   parameter int SUBW        = 3,
   parameter int SYNC_STAGES = 2,
   localparam int PTRW       = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_i,
   input  logic            sda_i,
   output logic            sda_oe_o,
   input  logic            addr_sel_i,
   input  logic [SUBW-1:0] hw_sub_i,
   output logic            ram_we_o,
   output logic [PTRW-1:0] ram_addr_o,
   output logic [7:0]      ram_wdata_o,
   output logic [1:0]      mux_o,
   output logic            bias_o,
   output logic            disp_en_o,
   output logic            bank_in_o,
   output logic            bank_out_o,
   output logic            blink_alt_o,
   output logic [1:0]      blink_freq_o
);

   generate
      if (DEPTH < 2 || DEPTH > 128) begin : g_bad_depth
         $error("lcdlink_rx: DEPTH must lie in 2..128 (7-bit pointer field)");
      end
      if (SUBW < 1 || SUBW > 3) begin : g_bad_subw
         $error("lcdlink_rx: SUBW must lie in 1..3 (3-bit select field)");
      end
   endgenerate

   logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   logic       data_stb, cmd_stb;
   logic [7:0] rx_byte;

   lcdlink_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start_ev), .stop_o(stop_ev)
   );

   lcdlink_frame frame_i (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev), .addr_sel_i(addr_sel_i),
      .sda_oe_o(sda_oe_o), .data_stb_o(data_stb), .cmd_stb_o(cmd_stb), .byte_o(rx_byte)
   );

   lcdlink_regs #(.DEPTH(DEPTH), .SUBW(SUBW), .PTRW(PTRW)) regs_i (
      .clk(clk), .rst_n(rst_n), .data_stb_i(data_stb), .cmd_stb_i(cmd_stb),
      .byte_i(rx_byte), .hw_sub_i(hw_sub_i),
      .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
      .mux_o(mux_o), .bias_o(bias_o), .disp_en_o(disp_en_o),
      .bank_in_o(bank_in_o), .bank_out_o(bank_out_o),
      .blink_alt_o(blink_alt_o), .blink_freq_o(blink_freq_o)
   );

endmodule

// File: rtl/lcdlink_chk.sv
`timescale 1ns/1ps
module lcdlink_chk #(
   parameter int DEPTH = 80,
   parameter int PTRW  = 7
) (
   input logic            clk,
   input logic            rst_n,
   input logic            scl_s,
   input logic            stop_ev,
   input logic            data_stb,
   input logic            cmd_stb,
   input logic            sda_oe_o,
   input logic            ram_we_o,
   input logic [PTRW-1:0] ram_addr_o,
   input logic [1:0]      mux_o,
   input logic            bias_o,
   input logic            disp_en_o,
   input logic            bank_in_o,
   input logic            bank_out_o,
   input logic            blink_alt_o,
   input logic [1:0]      blink_freq_o
);

   logic [8:0] cfg;
   assign cfg = {mux_o, bias_o, disp_en_o, bank_in_o, bank_out_o, blink_alt_o, blink_freq_o};

   AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we_o |=> !ram_we_o); // R5

   AST_WE_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we_o |-> $past(data_stb)); // R5

   AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we_o |-> (int'(ram_addr_o) < DEPTH)); // R5

   AST_ACK_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !scl_s); // R3

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !sda_oe_o); // R11

   AST_CFG_ONLY_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_stb |=> $stable(cfg)); // R7

   AST_ROUTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      data_stb |-> !cmd_stb); // R4

endmodule

bind lcdlink_rx lcdlink_chk #(.DEPTH(DEPTH), .PTRW(PTRW)) chk_i (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_ev(stop_ev),
   .data_stb(data_stb), .cmd_stb(cmd_stb), .sda_oe_o(sda_oe_o),
   .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o),
   .mux_o(mux_o), .bias_o(bias_o), .disp_en_o(disp_en_o),
   .bank_in_o(bank_in_o), .bank_out_o(bank_out_o),
   .blink_alt_o(blink_alt_o), .blink_freq_o(blink_freq_o)
);

// File: tb/lcdlink_rx_tb_top.sv
`timescale 1ns/1ps
module lcdlink_rx_tb_top;

   localparam int DEPTH  = 80;
   localparam int Q      = 6;
   localparam int HW_SUB = 1;
   localparam int K_NONE = 0;
   localparam int K_ACK  = 1;
   localparam int K_DATA = 2;
   localparam int K_CMD  = 3;

   typedef struct packed {
      logic       oe;
      logic       we;
      logic [6:0] addr;
      logic [7:0] data;
      logic [8:0] cfg;
   } snap_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic addr_sel = 1'b0;
   logic sda_bus;

   logic       sda_oe, ram_we, bias, disp_en, bank_in, bank_out, blink_alt;
   logic [6:0] ram_addr;
   logic [7:0] ram_wdata;
   logic [1:0] mux, blink_freq;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 0;

   // behavioural model state
   int   m_ptr = 0, m_sub = 0;
   logic [1:0] m_mux = 0, m_freq = 0;
   logic m_bias = 0, m_en = 0, m_bin = 0, m_bout = 0, m_alt = 0;
   logic exp_oe = 0, exp_we = 0;
   logic [6:0] exp_addr = 0;
   logic [7:0] exp_data = 0;
   int   exp_mem [DEPTH];
   int   got_mem [DEPTH];
   snap_t h0, h1;

   always #10 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   lcdlink_rx #(.DEPTH(DEPTH), .SUBW(3), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
      .addr_sel_i(addr_sel), .hw_sub_i(3'(HW_SUB)),
      .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
      .mux_o(mux), .bias_o(bias), .disp_en_o(disp_en),
      .bank_in_o(bank_in), .bank_out_o(bank_out),
      .blink_alt_o(blink_alt), .blink_freq_o(blink_freq)
   );

   function automatic logic [8:0] model_cfg();
      return {m_mux, m_bias, m_en, m_bin, m_bout, m_alt, m_freq};
   endfunction

   function automatic logic [8:0] dut_cfg();
      return {mux, bias, disp_en, bank_in, bank_out, blink_alt, blink_freq};
   endfunction

   function automatic snap_t cur_snap();
      snap_t s;
      s.oe = exp_oe; s.we = exp_we; s.addr = exp_addr; s.data = exp_data; s.cfg = model_cfg();
      return s;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // per-clock comparison: outputs lag a bus change by three clocks
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(sda_oe === h1.oe, "R3", "sda_oe per clock", sda_oe, h1.oe);
         chk(ram_we === h1.we, "R5", "ram_we per clock", ram_we, h1.we);
         if (h1.we)
            chk({ram_addr, ram_wdata} === {h1.addr, h1.data}, "R5", "write addr/data",
                {ram_addr, ram_wdata}, {h1.addr, h1.data});
         chk(dut_cfg() === h1.cfg, "R7", "config per clock", dut_cfg(), h1.cfg);
         if (ram_we) got_mem[ram_addr] = ram_wdata;
      end
      h1 = h0;
      h0 = cur_snap();
      exp_we = 0;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drv(input logic c, input logic d);
      @(negedge clk);
      #2;
      scl_m = c;
      sda_m = d;
   endtask

   task automatic model_data(input logic [7:0] b);
      if (m_sub == HW_SUB) begin
         exp_we = 1; exp_addr = 7'(m_ptr); exp_data = b; exp_mem[m_ptr] = b;
      end
      m_ptr++;
      if (m_ptr == DEPTH) begin
         m_ptr = 0;
         m_sub = (m_sub + 1) % 8;
      end
   endtask

   task automatic model_cmd(input logic [7:0] b);
      int v = int'(b);
      if (v < 128)                  m_ptr = (v < DEPTH) ? v : 0;
      else if (v < 192)             begin m_en = b[3]; m_bias = b[2]; m_mux = b[1:0]; end
      else if (v >= 224 && v < 232) m_sub = v % 8;
      else if (v >= 232 && v < 240) begin m_alt = b[2]; m_freq = b[1:0]; end
      else if (v >= 248 && v < 252) begin m_bin = b[1]; m_bout = b[0]; end
   endtask

   task automatic put_byte(input logic [7:0] b, input int kind, input string tag);
      logic ack = (kind != K_NONE);
      for (int i = 7; i >= 0; i--) begin
         drv(1'b0, b[i]); idle(Q);
         drv(1'b1, b[i]); if (i == 0 && kind == K_DATA) model_data(b); idle(Q);
         drv(1'b0, b[i]); if (i == 0 && ack) exp_oe = 1; idle(Q);
      end
      drv(1'b0, 1'b1); idle(Q);
      drv(1'b1, 1'b1); idle(Q);
      chk(sda_oe === ack, tag, "acknowledge level", sda_oe, ack);
      drv(1'b0, 1'b1); exp_oe = 0; if (kind == K_CMD) model_cmd(b); idle(Q);
   endtask

   task automatic start_cond();
      drv(1'b0, 1'b1); idle(Q);
      drv(1'b1, 1'b1); idle(Q);
      drv(1'b1, 1'b0); idle(Q);
      drv(1'b0, 1'b0); idle(Q);
   endtask

   task automatic stop_cond();
      drv(1'b0, 1'b0); idle(Q);
      drv(1'b1, 1'b0); idle(Q);
      drv(1'b1, 1'b1); idle(Q);
   endtask

   task automatic check_state(input string tag);
      chk(dut_cfg() === model_cfg(), tag, "config registers", dut_cfg(), model_cfg());
   endtask

   task automatic check_mem(input string tag);
      for (int a = 0; a < DEPTH; a++)
         chk(got_mem[a] == exp_mem[a], tag, $sformatf("RAM word %0d", a), got_mem[a], exp_mem[a]);
   endtask

   initial begin
      for (int a = 0; a < DEPTH; a++) begin exp_mem[a] = -1; got_mem[a] = -1; end
      h0 = cur_snap();
      h1 = cur_snap();
      repeat (5) @(negedge clk);
      #2 rst_n = 1'b1;
      idle(4);

      // R10: reset state
      check_state("R10");
      chk({sda_oe, ram_we} === 2'b00, "R10", "oe/we after reset", {sda_oe, ram_we}, 0);

      // R1: other address (addr_sel=0, address 0111001) is ignored
      start_cond();
      put_byte(8'h72, K_NONE, "R1");
      put_byte(8'h40, K_NONE, "R1");
      put_byte(8'h55, K_NONE, "R1");
      stop_cond();

      // R2: read to matching address is refused
      start_cond();
      put_byte(8'h71, K_NONE, "R2");
      put_byte(8'h40, K_NONE, "R2");
      stop_cond();
      check_mem("R2");

      // R7 / R8 / R5: commands then data
      start_cond();
      put_byte(8'h70, K_ACK, "R1");
      put_byte(8'h80, K_ACK, "R4");
      put_byte(8'hE1, K_CMD, "R8");
      put_byte(8'h80, K_ACK, "R4");
      put_byte(8'h8D, K_CMD, "R7");
      put_byte(8'h80, K_ACK, "R4");
      put_byte(8'h05, K_CMD, "R8");
      put_byte(8'h40, K_ACK, "R4");
      put_byte(8'hA1, K_DATA, "R5");
      put_byte(8'hB2, K_DATA, "R5");
      put_byte(8'hC3, K_DATA, "R5");
      stop_cond();
      check_state("R7");
      check_mem("R5");

      // R9: blink, bank and unrecognised codes under a single last-control byte
      start_cond();
      put_byte(8'h70, K_ACK, "R1");
      put_byte(8'h00, K_ACK, "R4");
      put_byte(8'hEE, K_CMD, "R9");
      put_byte(8'hFA, K_CMD, "R9");
      put_byte(8'hF3, K_CMD, "R9");
      put_byte(8'hC0, K_CMD, "R9");
      stop_cond();
      check_state("R9");

      // R5 / R6: wrap into next subaddress, then repeated START (R11)
      start_cond();
      put_byte(8'h70, K_ACK, "R1");
      put_byte(8'h80, K_ACK, "R4");
      put_byte(8'h4E, K_CMD, "R8");
      put_byte(8'h40, K_ACK, "R4");
      put_byte(8'h11, K_DATA, "R5");
      put_byte(8'h22, K_DATA, "R5");
      put_byte(8'h33, K_DATA, "R6");
      put_byte(8'h44, K_DATA, "R6");
      start_cond();
      put_byte(8'h70, K_ACK, "R11");
      put_byte(8'h80, K_ACK, "R11");
      put_byte(8'hE1, K_CMD, "R8");
      put_byte(8'h40, K_ACK, "R4");
      put_byte(8'h55, K_DATA, "R6");
      stop_cond();
      check_mem("R6");

      // R11: bytes clocked after STOP without a START are ignored
      put_byte(8'h70, K_NONE, "R11");
      put_byte(8'h99, K_NONE, "R11");
      drv(1'b1, 1'b1); idle(Q);
      check_mem("R11");

      // R1 with addr_sel=1, and R4 alternation with continue bit set
      @(negedge clk); #2 addr_sel = 1'b1;
      start_cond();
      put_byte(8'h70, K_NONE, "R1");
      stop_cond();
      start_cond();
      put_byte(8'h72, K_ACK, "R1");
      put_byte(8'hC0, K_ACK, "R4");
      put_byte(8'h66, K_DATA, "R4");
      put_byte(8'h80, K_ACK, "R4");
      put_byte(8'h82, K_CMD, "R7");
      put_byte(8'h40, K_ACK, "R4");
      put_byte(8'h77, K_DATA, "R4");
      stop_cond();
      check_state("R4");
      check_mem("R4");

      idle(10);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule